// File: doc/BRIEF.md
# Software-Filled Translation Buffer

This block translates virtual addresses with a small fully associative table that software fills itself. Software writes five word-wide registers through a simple register port. It stages an effective page and its address-space tag in the page-tag register, and page size, guard and access-group attributes in the walk-attribute register. A write to the frame register then places one complete entry into the slot named by the index field of the control register. The index then moves on to the next slot.

The lookup side takes a virtual address and a valid strobe. It compares the address against every slot, using the tag held in the context register. One cycle later it reports a hit, the physical address, the guard bit, the access group and a multi-hit flag. Each entry has its own page size of 4K, 16K, 512K or 8M, so the number of untranslated low address bits differs from slot to slot. On a miss, the page-tag register is loaded with the faulting page so that a refill handler can read it back.

The lookup result comes from a four-state machine: `LK_IDLE` (no lookup), `LK_HIT` (one slot matched), `LK_MISS` (no slot matched) and `LK_MULTI` (several slots matched). In every cycle the state moves to `LK_IDLE` when the strobe is low. Otherwise it moves to `LK_MULTI` when two or more slots match, to `LK_HIT` when exactly one matches, and to `LK_MISS` when none does.

Top module: `soft_tlb`

## Requirements
- R1: After reset the control register reads the parameter CTRL_RESET (default 0x04000000), every other register reads 0, no slot is valid, and lk_hit and lk_multi are 0.
- R2: A write to the frame register (address 3) stores one entry in the slot given by control bits 12:8. The entry takes its page number from page-tag bits 31:12, its tag from page-tag bits 3:0 and its frame from the written bits 31:12. A lookup presented in the cycle after that write sees the new entry.
- R3: The page size is set by walk-attribute bits 3:2: 11 selects 8M, 01 selects 512K, and 00 or 10 selects 16K when frame bit 3 is set and 4K otherwise. The low 12, 14, 19 or 23 address bits pass through untranslated, and only the bits above them are compared and replaced.
- R4: A slot hits only if page-tag bit 9 and walk-attribute bit 0 were both set when it was written, its tag equals context bits 3:0, and the compared page bits are equal.
- R5: A lookup that misses loads the page-tag register with the looked-up address bits 31:12 in bits 31:12, the current context tag in bits 3:0, and zero in all other bits, including bit 9.
- R6: After each commit the index advances by one. From the last slot it wraps to 0, or to 4 when control bit 27 is set. With bit 27 set, the index never advances into slots 0 to 3, although an index written directly into that range still commits there.
- R7: When several slots hit, the lowest-numbered slot supplies the result and lk_multi is 1.
- R8: Reads at addresses 0 (control), 1 (page tag), 2 (walk attribute), 3 (frame) and 4 (context) return the stored values. Writes keep all control and frame bits, page-tag bits under mask 0xFFFFF20F, walk-attribute bits under mask 0x000001FD and context bits under mask 0xF. Other addresses read 0.
- R9: The result appears one cycle after lk_valid. lk_guarded is walk-attribute bit 4 and lk_apg is walk-attribute bits 8:5 of the winning slot. All result outputs are 0 after a cycle with lk_valid low or after a miss.
- R10: When a miss and a page-tag register write happen in the same cycle, the miss information is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| lk_valid | input | 1 | Lookup strobe |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | A slot matched |
| lk_paddr | output | 32 | Translated address |
| lk_guarded | output | 1 | Guard bit of the winning slot |
| lk_apg | output | 4 | Access group of the winning slot |
| lk_multi | output | 1 | Several slots matched |

## Verification
The hardest situations to reach are those where the index wraps with and without the reservation bit, and where two slots map the same page. Both need a long, ordered series of register writes before a single lookup can show them. The directed stimulus steers the index to slot 31, writes an index inside the reserved range directly, and commits a duplicate mapping into a higher slot. It also places a miss in the same cycle as a page-tag write. A random phase afterwards mixes commits of all four page sizes with lookups confined to a few mapped regions, so that hits, misses and multi-hits recur.

// File: rtl/stlb_pkg.sv
package stlb_pkg;

    typedef enum logic [1:0] {
        PG_4K   = 2'd0,
        PG_16K  = 2'd1,
        PG_512K = 2'd2,
        PG_8M   = 2'd3
    } pg_size_e;

    typedef enum logic [1:0] {
        LK_IDLE  = 2'd0,
        LK_HIT   = 2'd1,
        LK_MISS  = 2'd2,
        LK_MULTI = 2'd3
    } lk_state_e;

    typedef struct packed {
        logic       valid;
        logic [19:0] vpn;
        logic [3:0]  asid;
        logic [19:0] ppn;
        pg_size_e    size;
        logic        guarded;
        logic [3:0]  apg;
    } tlb_entry_t;

    localparam logic [2:0] REG_CTRL  = 3'd0;
    localparam logic [2:0] REG_EPN   = 3'd1;
    localparam logic [2:0] REG_TWC   = 3'd2;
    localparam logic [2:0] REG_RPN   = 3'd3;
    localparam logic [2:0] REG_CASID = 3'd4;

    localparam logic [31:0] EPN_MASK   = 32'hFFFF_F20F;
    localparam logic [31:0] TWC_MASK   = 32'h0000_01FD;
    localparam logic [31:0] CASID_MASK = 32'h0000_000F;

    localparam int CTRL_IDX_LSB = 8;
    localparam int CTRL_RES_BIT = 27;

    // Page-number bits that take part in comparison for each size
    function automatic logic [19:0] vpn_mask(input pg_size_e s);
        logic [19:0] m;
        unique case (s)
            PG_4K:   m = 20'hFFFFF;
            PG_16K:  m = 20'hFFFFC;
            PG_512K: m = 20'hFFF80;
            PG_8M:   m = 20'hFF800;
            default: m = 20'hFFFFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/stlb_regs.sv
module stlb_regs
    import stlb_pkg::*;
#(
    parameter int          N_ENTRIES  = 32,
    parameter int          N_RESERVED = 4,
    parameter logic [31:0] CTRL_RESET = 32'h0400_0000,
    localparam int         IDX_W      = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             miss_capture,
    input  logic [19:0]      miss_vpn,
    output logic [3:0]       casid,
    output logic             commit_we,
    output logic [IDX_W-1:0] commit_idx,
    output tlb_entry_t       commit_entry,
    output logic [31:0]      ctrl_word,
    output logic [31:0]      epn_word
);

    logic [31:0] ctrl_q, epn_q, twc_q, rpn_q, casid_q;
    logic [IDX_W-1:0] next_idx;
    logic reserve;

    assign reserve    = ctrl_q[CTRL_RES_BIT];
    assign commit_we  = reg_we && (reg_addr == REG_RPN);
    assign commit_idx = ctrl_q[CTRL_IDX_LSB +: IDX_W];

    // Index that follows the current one after a commit
    always_comb begin
        int cur;
        int nxt;
        cur = int'(commit_idx);
        nxt = cur + 1;
        if (nxt >= N_ENTRIES) begin
            nxt = reserve ? N_RESERVED : 0;
        end
        if (reserve && (nxt < N_RESERVED)) begin
            nxt = N_RESERVED;
        end
        next_idx = IDX_W'(nxt);
    end

    // Entry assembled from the staged registers and the written frame
    always_comb begin
        commit_entry.valid   = epn_q[9] & twc_q[0];
        commit_entry.vpn     = epn_q[31:12];
        commit_entry.asid    = epn_q[3:0];
        commit_entry.ppn     = reg_wdata[31:12];
        commit_entry.guarded = twc_q[4];
        commit_entry.apg     = twc_q[8:5];
        unique case (twc_q[3:2])
            2'b11:   commit_entry.size = PG_8M;
            2'b01:   commit_entry.size = PG_512K;
            default: commit_entry.size = reg_wdata[3] ? PG_16K : PG_4K;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_RESET;
            epn_q   <= '0;
            twc_q   <= '0;
            rpn_q   <= '0;
            casid_q <= '0;
        end else begin
            if (reg_we && (reg_addr == REG_CTRL)) begin
                ctrl_q <= reg_wdata;
            end else if (commit_we) begin
                ctrl_q[CTRL_IDX_LSB +: IDX_W] <= next_idx;
            end

            if (miss_capture) begin
                epn_q <= {miss_vpn, 8'h00, casid_q[3:0]};
            end else if (reg_we && (reg_addr == REG_EPN)) begin
                epn_q <= reg_wdata & EPN_MASK;
            end

            if (reg_we && (reg_addr == REG_TWC)) begin
                twc_q <= reg_wdata & TWC_MASK;
            end
            if (commit_we) begin
                rpn_q <= reg_wdata;
            end
            if (reg_we && (reg_addr == REG_CASID)) begin
                casid_q <= reg_wdata & CASID_MASK;
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            REG_CTRL:  reg_rdata = ctrl_q;
            REG_EPN:   reg_rdata = epn_q;
            REG_TWC:   reg_rdata = twc_q;
            REG_RPN:   reg_rdata = rpn_q;
            REG_CASID: reg_rdata = casid_q;
            default:   reg_rdata = '0;
        endcase
    end

    assign casid     = casid_q[3:0];
    assign ctrl_word = ctrl_q;
    assign epn_word  = epn_q;

endmodule

// File: rtl/stlb_array.sv
module stlb_array
    import stlb_pkg::*;
#(
    parameter int  N_ENTRIES = 32,
    localparam int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_entry_t       wr_entry,
    input  logic [19:0]      lk_vpn,
    input  logic [3:0]       lk_asid,
    output logic [N_ENTRIES-1:0] match_vec,
    output logic [19:0]      ppn_o   [N_ENTRIES],
    output pg_size_e         size_o  [N_ENTRIES],
    output logic             guard_o [N_ENTRIES],
    output logic [3:0]       apg_o   [N_ENTRIES]
);

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
        tlb_entry_t  ent_q;
        logic [19:0] cmp_mask;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                ent_q <= wr_entry;
            end
        end

        assign cmp_mask     = vpn_mask(ent_q.size);
        assign match_vec[g] = ent_q.valid
                              && (ent_q.asid == lk_asid)
                              && (((ent_q.vpn ^ lk_vpn) & cmp_mask) == 20'h0);
        assign ppn_o[g]     = ent_q.ppn;
        assign size_o[g]    = ent_q.size;
        assign guard_o[g]   = ent_q.guarded;
        assign apg_o[g]     = ent_q.apg;
    end

endmodule

// File: rtl/stlb_lookup.sv
module stlb_lookup
    import stlb_pkg::*;
#(
    parameter int  N_ENTRIES = 32,
    localparam int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lk_valid,
    input  logic [31:0]          lk_vaddr,
    input  logic [N_ENTRIES-1:0] match_vec,
    input  logic [19:0]          ppn_i   [N_ENTRIES],
    input  pg_size_e             size_i  [N_ENTRIES],
    input  logic                 guard_i [N_ENTRIES],
    input  logic [3:0]           apg_i   [N_ENTRIES],
    output logic                 miss_now,
    output logic                 lk_hit,
    output logic [31:0]          lk_paddr,
    output logic                 lk_guarded,
    output logic [3:0]           lk_apg,
    output logic                 lk_multi
);

    lk_state_e        state_q, state_d;
    logic [IDX_W-1:0] sel;
    logic             any_match;
    logic [19:0]      keep_mask;
    logic [31:0]      pa_d, pa_q;
    logic             g_q;
    logic [3:0]       apg_q;

    // Lowest-numbered matching slot wins
    always_comb begin
        sel = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                sel = IDX_W'(i);
            end
        end
    end

    assign any_match = |match_vec;
    assign miss_now  = lk_valid && !any_match;
    assign keep_mask = vpn_mask(size_i[sel]);
    assign pa_d      = {(ppn_i[sel] & keep_mask) | (lk_vaddr[31:12] & ~keep_mask),
                        lk_vaddr[11:0]};

    always_comb begin
        if (!lk_valid) begin
            state_d = LK_IDLE;
        end else if ($countones(match_vec) > 1) begin
            state_d = LK_MULTI;
        end else if (any_match) begin
            state_d = LK_HIT;
        end else begin
            state_d = LK_MISS;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Translation captured alongside the state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa_q  <= '0;
            g_q   <= 1'b0;
            apg_q <= '0;
        end else begin
            pa_q  <= pa_d;
            g_q   <= guard_i[sel];
            apg_q <= apg_i[sel];
        end
    end

    // Outputs decoded from the state
    always_comb begin
        lk_hit     = 1'b0;
        lk_multi   = 1'b0;
        lk_paddr   = '0;
        lk_guarded = 1'b0;
        lk_apg     = '0;
        unique case (state_q)
            LK_IDLE, LK_MISS: begin
                lk_hit = 1'b0;
            end
            LK_HIT: begin
                lk_hit     = 1'b1;
                lk_paddr   = pa_q;
                lk_guarded = g_q;
                lk_apg     = apg_q;
            end
            LK_MULTI: begin
                lk_hit     = 1'b1;
                lk_multi   = 1'b1;
                lk_paddr   = pa_q;
                lk_guarded = g_q;
                lk_apg     = apg_q;
            end
            default: begin
                lk_hit = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
    import stlb_pkg::*;
#(
    parameter int          N_ENTRIES  = 32,
    parameter int          N_RESERVED = 4,
    parameter logic [31:0] CTRL_RESET = 32'h0400_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        lk_valid,
    input  logic [31:0] lk_vaddr,
    output logic        lk_hit,
    output logic [31:0] lk_paddr,
    output logic        lk_guarded,
    output logic [3:0]  lk_apg,
    output logic        lk_multi
);

    localparam int IDX_W = $clog2(N_ENTRIES);

    logic             miss_now;
    logic [3:0]       casid;
    logic             commit_we;
    logic [IDX_W-1:0] commit_idx;
    tlb_entry_t       commit_entry;
    logic [31:0]      ctrl_word;
    logic [31:0]      epn_word;
    logic [N_ENTRIES-1:0] match_vec;
    logic [19:0]      slot_ppn   [N_ENTRIES];
    pg_size_e         slot_size  [N_ENTRIES];
    logic             slot_guard [N_ENTRIES];
    logic [3:0]       slot_apg   [N_ENTRIES];

    stlb_regs #(
        .N_ENTRIES (N_ENTRIES),
        .N_RESERVED(N_RESERVED),
        .CTRL_RESET(CTRL_RESET)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .miss_capture(miss_now),
        .miss_vpn    (lk_vaddr[31:12]),
        .casid       (casid),
        .commit_we   (commit_we),
        .commit_idx  (commit_idx),
        .commit_entry(commit_entry),
        .ctrl_word   (ctrl_word),
        .epn_word    (epn_word)
    );

    stlb_array #(
        .N_ENTRIES(N_ENTRIES)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (commit_we),
        .wr_idx   (commit_idx),
        .wr_entry (commit_entry),
        .lk_vpn   (lk_vaddr[31:12]),
        .lk_asid  (casid),
        .match_vec(match_vec),
        .ppn_o    (slot_ppn),
        .size_o   (slot_size),
        .guard_o  (slot_guard),
        .apg_o    (slot_apg)
    );

    stlb_lookup #(
        .N_ENTRIES(N_ENTRIES)
    ) u_lookup (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .lk_vaddr  (lk_vaddr),
        .match_vec (match_vec),
        .ppn_i     (slot_ppn),
        .size_i    (slot_size),
        .guard_i   (slot_guard),
        .apg_i     (slot_apg),
        .miss_now  (miss_now),
        .lk_hit    (lk_hit),
        .lk_paddr  (lk_paddr),
        .lk_guarded(lk_guarded),
        .lk_apg    (lk_apg),
        .lk_multi  (lk_multi)
    );

endmodule

// File: rtl/soft_tlb_chk.sv
module soft_tlb_chk
    import stlb_pkg::*;
#(
    parameter int N_ENTRIES  = 32,
    parameter int N_RESERVED = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_we,
    input logic [2:0]           reg_addr,
    input logic                 lk_valid,
    input logic [31:0]          lk_vaddr,
    input logic                 lk_hit,
    input logic [31:0]          lk_paddr,
    input logic                 lk_multi,
    input logic [N_ENTRIES-1:0] match_vec,
    input logic                 commit_we,
    input logic                 ctrl_res,
    input logic [4:0]           ctrl_idx,
    input logic [19:0]          epn_page,
    input logic                 epn_valid
);

    AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_multi |-> lk_hit); // R7

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!lk_hit && !lk_multi && (lk_paddr == 32'h0))); // R9

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!lk_hit || (lk_paddr[11:0] == $past(lk_vaddr[11:0])))); // R3

    AST_NO_MATCH_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && (match_vec == '0)) |=> !lk_hit); // R4

    AST_MISS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && (match_vec == '0)) |=>
            ((epn_page == $past(lk_vaddr[31:12])) && !epn_valid)); // R5

    AST_RESERVE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_we && ctrl_res && !(reg_we && (reg_addr == REG_CTRL)))
            |=> (int'(ctrl_idx) >= N_RESERVED)); // R6

endmodule

bind soft_tlb soft_tlb_chk #(
    .N_ENTRIES (N_ENTRIES),
    .N_RESERVED(N_RESERVED)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .lk_valid (lk_valid),
    .lk_vaddr (lk_vaddr),
    .lk_hit   (lk_hit),
    .lk_paddr (lk_paddr),
    .lk_multi (lk_multi),
    .match_vec(match_vec),
    .commit_we(commit_we),
    .ctrl_res (ctrl_word[27]),
    .ctrl_idx (ctrl_word[12:8]),
    .epn_page (epn_word[31:12]),
    .epn_valid(epn_word[9])
);

// File: tb/soft_tlb_test.sv
`timescale 1ns/1ps
module soft_tlb_test;

    localparam int NE = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit;
    logic [31:0] lk_paddr;
    logic        lk_guarded;
    logic [3:0]  lk_apg;
    logic        lk_multi;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    soft_tlb uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
        .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
        .lk_guarded(lk_guarded), .lk_apg(lk_apg), .lk_multi(lk_multi)
    );

    // Behavioural reference state
    logic [31:0] m_ctrl, m_epn, m_twc, m_rpn, m_casid;
    bit          m_v   [NE];
    logic [31:0] m_va  [NE];
    logic [31:0] m_pa  [NE];
    int          m_off [NE];
    logic [3:0]  m_asid[NE];
    logic [3:0]  m_apg [NE];
    bit          m_g   [NE];
    logic        e_hit, e_multi, e_g;
    logic [31:0] e_pa;
    logic [3:0]  e_apg;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_ctrl;
            3'd1: return m_epn;
            3'd2: return m_twc;
            3'd3: return m_rpn;
            3'd4: return m_casid;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_reset();
        m_ctrl = 32'h0400_0000;
        m_epn = 0; m_twc = 0; m_rpn = 0; m_casid = 0;
        for (int i = 0; i < NE; i++) begin
            m_v[i] = 0; m_va[i] = 0; m_pa[i] = 0; m_off[i] = 12;
            m_asid[i] = 0; m_apg[i] = 0; m_g[i] = 0;
        end
    endtask

    // One clock: drive, predict, clock, compare
    task automatic cyc(input bit we, input logic [2:0] a, input logic [31:0] d,
                       input bit lv, input logic [31:0] va);
        logic [31:0] nctrl, nepn, ntwc, nrpn, ncas;
        int hits, first, cur, nx, off;
        reg_we = we; reg_addr = a; reg_wdata = d; lk_valid = lv; lk_vaddr = va;
        hits = 0; first = -1;
        for (int i = 0; i < NE; i++) begin
            if (m_v[i] && (m_asid[i] == m_casid[3:0]) &&
                ((m_va[i] >> m_off[i]) == (va >> m_off[i]))) begin
                hits++;
                if (first < 0) first = i;
            end
        end
        e_hit = lv && (hits > 0);
        e_multi = lv && (hits > 1);
        if (e_hit) begin
            e_pa = ((m_pa[first] >> m_off[first]) << m_off[first]) |
                   (va & ((32'h1 << m_off[first]) - 1));
            e_g = m_g[first];
            e_apg = m_apg[first];
        end else begin
            e_pa = 0; e_g = 0; e_apg = 0;
        end
        nctrl = m_ctrl; nepn = m_epn; ntwc = m_twc; nrpn = m_rpn; ncas = m_casid;
        if (we && a == 3'd3) begin
            cur = int'((m_ctrl >> 8) & 32'h1F);
            if (m_twc[3:2] == 2'b11) off = 23;
            else if (m_twc[3:2] == 2'b01) off = 19;
            else off = d[3] ? 14 : 12;
            m_v[cur] = m_epn[9] && m_twc[0];
            m_va[cur] = m_epn & 32'hFFFF_F000;
            m_asid[cur] = m_epn[3:0];
            m_pa[cur] = d & 32'hFFFF_F000;
            m_off[cur] = off;
            m_g[cur] = m_twc[4];
            m_apg[cur] = m_twc[8:5];
            nx = cur + 1;
            if (nx == NE) nx = m_ctrl[27] ? 4 : 0;
            if (m_ctrl[27] && nx < 4) nx = 4;
            nctrl = (m_ctrl & ~32'h0000_1F00) | (32'(nx) << 8);
            nrpn = d;
        end
        if (we && a == 3'd0) nctrl = d;
        if (we && a == 3'd2) ntwc = d & 32'h0000_01FD;
        if (we && a == 3'd4) ncas = d & 32'hF;
        if (lv && hits == 0) nepn = (va & 32'hFFFF_F000) | {28'h0, m_casid[3:0]};
        else if (we && a == 3'd1) nepn = d & 32'hFFFF_F20F;
        @(posedge clk);
        @(negedge clk);
        m_ctrl = nctrl; m_epn = nepn; m_twc = ntwc; m_rpn = nrpn; m_casid = ncas;
        check("R4 lk_hit", {31'h0, lk_hit}, {31'h0, e_hit});
        check("R7 lk_multi", {31'h0, lk_multi}, {31'h0, e_multi});
        check("R3 lk_paddr", lk_paddr, e_pa);
        check("R9 lk_guarded", {31'h0, lk_guarded}, {31'h0, e_g});
        check("R9 lk_apg", {28'h0, lk_apg}, {28'h0, e_apg});
        check("R8 reg_rdata", reg_rdata, model_read(a));
    endtask

    task automatic load(input logic [31:0] epn, input logic [31:0] twc, input logic [31:0] rpn);
        cyc(1, 3'd1, epn, 0, 0);
        cyc(1, 3'd2, twc, 0, 0);
        cyc(1, 3'd3, rpn, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog act=%h exp=%h", 32'h0, 32'h1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 ctrl reset", reg_rdata, 32'h0400_0000);
        check("R1 hit reset", {31'h0, lk_hit}, 32'h0);
        check("R1 multi reset", {31'h0, lk_multi}, 32'h0);
        cyc(0, 3'd1, 0, 1, 32'h1000_0000);
        check("R1 no valid slot", {31'h0, lk_hit}, 32'h0);

        // Register masks
        cyc(1, 3'd2, 32'hFFFF_FFFF, 0, 0);
        check("R8 twc mask", reg_rdata, 32'h0000_01FD);
        cyc(1, 3'd1, 32'hFFFF_FFFF, 0, 0);
        check("R8 epn mask", reg_rdata, 32'hFFFF_F20F);
        cyc(1, 3'd4, 32'hFFFF_FFFF, 0, 0);
        check("R8 casid mask", reg_rdata, 32'h0000_000F);
        cyc(1, 3'd4, 32'h5, 0, 0);

        // 4K entry, slot 0
        load(32'h1000_0205, 32'h0000_0071, 32'hABCD_E000);
        cyc(0, 3'd0, 0, 0, 0);
        check("R6 index after commit", reg_rdata, 32'h0400_0100);
        cyc(0, 3'd0, 0, 1, 32'h1000_0123);
        check("R2 4K translate", lk_paddr, 32'hABCD_E123);
        check("R9 guarded", {31'h0, lk_guarded}, 32'h1);
        check("R9 apg", {28'h0, lk_apg}, 32'h3);
        cyc(0, 3'd0, 0, 0, 0);
        check("R9 idle paddr", lk_paddr, 32'h0);
        check("R9 idle hit", {31'h0, lk_hit}, 32'h0);

        // 16K, 512K, 8M
        load(32'h2000_0205, 32'h0000_0001, 32'h1234_4008);
        cyc(0, 3'd0, 0, 1, 32'h2000_3ABC);
        check("R3 16K translate", lk_paddr, 32'h1234_7ABC);
        cyc(0, 3'd0, 0, 1, 32'h2000_4000);
        check("R3 16K boundary miss", {31'h0, lk_hit}, 32'h0);
        load(32'h4000_0205, 32'h0000_0005, 32'h8000_0000);
        cyc(0, 3'd0, 0, 1, 32'h4007_FFFF);
        check("R3 512K translate", lk_paddr, 32'h8007_FFFF);
        load(32'h6000_0205, 32'h0000_000D, 32'h0080_0000);
        cyc(0, 3'd0, 0, 1, 32'h607F_FFF0);
        check("R3 8M translate", lk_paddr, 32'h00FF_FFF0);

        // Tag mismatch and miss capture
        cyc(1, 3'd4, 32'h6, 0, 0);
        cyc(0, 3'd1, 0, 1, 32'h1000_0123);
        check("R4 tag mismatch miss", {31'h0, lk_hit}, 32'h0);
        check("R5 miss captured", reg_rdata, 32'h1000_0006);
        cyc(1, 3'd4, 32'h5, 0, 0);

        // Invalid flags
        load(32'h3000_0005, 32'h0000_0001, 32'h0000_1000);
        cyc(0, 3'd0, 0, 1, 32'h3000_0000);
        check("R4 page valid clear", {31'h0, lk_hit}, 32'h0);
        load(32'h5000_0205, 32'h0000_0000, 32'h0000_2000);
        cyc(0, 3'd0, 0, 1, 32'h5000_0000);
        check("R4 segment valid clear", {31'h0, lk_hit}, 32'h0);

        // Duplicate mapping in slot 6
        load(32'h1000_0205, 32'h0000_0001, 32'h7777_7000);
        cyc(0, 3'd0, 0, 1, 32'h1000_0456);
        check("R7 multi flag", {31'h0, lk_multi}, 32'h1);
        check("R7 lowest slot wins", lk_paddr, 32'hABCD_E456);

        // Reservation and wrap
        cyc(1, 3'd0, 32'h0800_1F00, 0, 0);
        load(32'h7000_0205, 32'h0000_0001, 32'h5555_5000);
        cyc(0, 3'd0, 0, 0, 0);
        check("R6 reserved wrap", reg_rdata, 32'h0800_0400);
        cyc(1, 3'd0, 32'h0800_0200, 0, 0);
        load(32'h4000_0205, 32'h0000_0005, 32'h9000_0000);
        cyc(0, 3'd0, 0, 1, 32'h4000_0010);
        check("R6 skip reserved range", reg_rdata, 32'h0800_0400);
        check("R6 direct reserved commit", lk_paddr, 32'h9000_0010);
        cyc(1, 3'd0, 32'h0000_1F00, 0, 0);
        load(32'h7000_0205, 32'h0000_0001, 32'h5555_5000);
        cyc(0, 3'd0, 0, 0, 0);
        check("R6 plain wrap", reg_rdata, 32'h0000_0000);

        // Miss and page-tag write together
        cyc(1, 3'd1, 32'hDEAD_F20F, 1, 32'hE000_1000);
        check("R10 miss beats write", reg_rdata, 32'hE000_1005);

        // Random mix
        for (int k = 0; k < 3000; k++) begin
            int op;
            logic [31:0] d;
            op = int'($urandom % 8);
            case (op)
                0: cyc(1, 3'd1, (($urandom % 4) << 28) | ($urandom & 32'h0000_3000) |
                       (($urandom % 4 == 0) ? 32'h0 : 32'h200) | (5 + $urandom % 2), 0, 0);
                1: cyc(1, 3'd2, $urandom & 32'h1FF, 0, 0);
                2: cyc(1, 3'd3, $urandom, 0, 0);
                3: begin
                    d = ($urandom & 32'h0800_1F00) | ($urandom & 32'h0400_00FF);
                    cyc(1, 3'd0, d, 0, 0);
                end
                4: cyc(1, 3'd4, 5 + $urandom % 2, 0, 0);
                default: cyc($urandom % 2 == 0, 3'($urandom % 8), $urandom, 1,
                             (($urandom % 4) << 28) | ($urandom & 32'h0000_3FFF));
            endcase
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule